// File: doc/BRIEF.md
# Exposure Gate Synchroniser

This block sits between a motion controller and the devices that must see an exposure. The motion controller emits one pulse when the sample reaches the starting angle and another when it reaches the final angle. The block turns those two pulses into three gate outputs: one for an X-ray shutter, one for the detector's integration gate and one for a beam-intensity monitor. No software sits in the timing path. Each trigger is resynchronised and edge-detected, and then it drives the gates with a fixed latency.

A mechanical shutter opens and closes roughly 40 ms after it is commanded, with about 1 ms of jitter. For this reason every output has its own opening delay and its own closing delay. The delays are counted in ticks of a prescaled time base, which is 10 us at the default setting. The shutter can then be commanded at once, while the electronic gates are held back so that they line up with the real light window. A host arms the block before each exposure through a small register port. The same port sets the delays and per-output enables and reads back a status word.

The exposure sequencer has three states:
- `SEQ_IDLE`: not armed.
- `SEQ_ARMED`: waiting for a start pulse.
- `SEQ_EXPOSE`: the window is open.

Its transitions are:
- arm-write moves `SEQ_IDLE` to `SEQ_ARMED`.
- accepted-start moves `SEQ_ARMED` to `SEQ_EXPOSE`.
- accepted-end moves `SEQ_EXPOSE` back to `SEQ_IDLE`, or to `SEQ_ARMED` if an arm-write arrives in the same cycle.

Each output channel has five states:
- `CH_IDLE`
- `CH_OPEN_WAIT`
- `CH_ON`
- `CH_CLOSE_LIT`: the gate stays on while the closing delay runs.
- `CH_CLOSE_DARK`: the closing delay runs but the gate never opened.

Its transitions are:
- An accepted start goes to `CH_ON` when the opening delay is 0, otherwise to `CH_OPEN_WAIT`. This applies from any channel state.
- An opening-delay expiry moves `CH_OPEN_WAIT` to `CH_ON`.
- An accepted end moves `CH_ON` to `CH_CLOSE_LIT` and `CH_OPEN_WAIT` to `CH_CLOSE_DARK`. Both go straight to `CH_IDLE` when the closing delay is 0.
- A closing-delay expiry moves either closing state to `CH_IDLE`.

Top module: `expo_gate_sync`

## Requirements
- R1: A trigger input that goes high before clock edge k is acted on at edge k+2. Trigger inputs are sampled through a two-stage synchroniser, and only a rising edge counts.
- R2: A start pulse is accepted only when the block is armed and not exposing. Otherwise the exposure state is unchanged. Writing register 0 with bit 0 set arms the block.
- R3: A start pulse that arrives while exposing does not disturb the exposure. It sets the sticky overrun flag, status bit 3. The flag is cleared only by writing register 0 with bit 2 set.
- R4: An end pulse while exposing has four effects: exposing (status bit 1) clears, done (status bit 2) sets, armed (status bit 0) clears, and the count of completed exposures increments. An end pulse while not exposing is ignored. Done clears when the next start is accepted.
- R5: The time base produces a one-cycle tick every TICK_DIV clocks. The first tick falls in the TICK_DIV-th cycle after reset. The default of 1250 gives 10 us at 125 MHz.
- R6: After an accepted start, a channel with opening delay D turns on at the edge that consumes the D-th tick. A tick in the same cycle as the start is not counted. With D = 0 the channel turns on at the same edge as exposing rises.
- R7: After an accepted end, an open channel with closing delay C turns off at the edge that consumes the C-th tick. With C = 0 it turns off at the same edge as exposing falls.
- R8: If the end pulse comes before a channel's opening delay has expired, that channel never turns on during this exposure.
- R9: The enable register (address 1) has bit 0 for the shutter, bit 1 for the detector and bit 2 for the monitor. While an enable bit is clear, that output is low. Setting the bit again shows the channel's live state on the next cycle.
- R10: The read of register 0 returns a status word:
  - bits 3:0: {overrun, done, exposing, armed}
  - bits 31:16: the completed-exposure count
  - all other bits: zero

  Writing register 0 with bit 1 set clears the count.
- R11: Delay registers are at address 2 (shutter), address 3 (detector) and address 4 (monitor). Bits 15:0 hold the opening delay and bits 31:16 the closing delay, both read back as written. Reset sets all registers, all status and all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_trig | input | 1 | Start-angle pulse from the motion controller, asynchronous |
| end_trig | input | 1 | End-angle pulse from the motion controller, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| shutter_gate | output | 1 | Shutter command gate |
| detector_gate | output | 1 | Detector integration gate |
| monitor_gate | output | 1 | Beam-intensity monitor gate |

## Verification
A sequencer in the wrong state shows up on the status word in the very next cycle. Examples are a sequencer that opens without being armed, or one that stays in the exposing state after an end pulse. The same fault shows up on the zero-delay shutter output at the same edge. A channel counter that drifts by one tick moves a gate edge by a whole time-base period. The reference model compares every gate on every clock, so such an error is reported within TICK_DIV cycles of the expected edge. A channel stuck in the dark-closing state, or one that leaks its state past its enable bit, would show a gate level that differs from the model for as long as the fault persists.

// File: rtl/expo_gate_pkg.sv
package expo_gate_pkg;

    localparam int N_CH   = 3;
    localparam int DLY_W  = 16;
    localparam int CNT_W  = 16;
    localparam int REG_AW = 3;
    localparam int REG_DW = 32;

    // register addresses; delay registers follow consecutively per channel
    localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
    localparam logic [REG_AW-1:0] A_EN   = 3'd1;
    localparam int                A_DLY0 = 2;

    // control write bits
    localparam int C_ARM     = 0;
    localparam int C_CLR_CNT = 1;
    localparam int C_CLR_OVR = 2;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_ARMED,
        SEQ_EXPOSE
    } seq_state_t;

    typedef enum logic [2:0] {
        CH_IDLE,
        CH_OPEN_WAIT,
        CH_ON,
        CH_CLOSE_LIT,
        CH_CLOSE_DARK
    } ch_state_t;

endpackage

// File: rtl/expo_edge_sync.sv
module expo_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic rise
);
    // stage 0 and 1 resynchronise, stage 2 holds the previous level
    logic [2:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[1:0], raw};
    end

    assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/expo_timebase.sv
module expo_timebase #(
    parameter int TICK_DIV = 1250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int PW = $clog2(TICK_DIV > 1 ? TICK_DIV : 2);
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pc;

    assign tick = (pc == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pc <= '0;
        else if (tick) pc <= '0;
        else           pc <= pc + 1'b1;
    end
endmodule

// File: rtl/expo_gate_chan.sv
module expo_gate_chan
    import expo_gate_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start_ev,
    input  logic          end_ev,
    input  logic [DW-1:0] open_dly,
    input  logic [DW-1:0] close_dly,
    input  logic          enable,
    output logic          lit,
    output logic          gate
);
    ch_state_t     st, st_nxt;
    logic [DW-1:0] cnt, cnt_nxt;
    logic [DW-1:0] cnt_inc;

    assign cnt_inc = cnt + 1'b1;

    // next state and tick counter
    always_comb begin
        st_nxt  = st;
        cnt_nxt = cnt;
        if (start_ev) begin
            st_nxt  = (open_dly == '0) ? CH_ON : CH_OPEN_WAIT;
            cnt_nxt = '0;
        end else if (end_ev && (st == CH_OPEN_WAIT || st == CH_ON)) begin
            cnt_nxt = '0;
            if (close_dly == '0)   st_nxt = CH_IDLE;
            else if (st == CH_ON)  st_nxt = CH_CLOSE_LIT;
            else                   st_nxt = CH_CLOSE_DARK;
        end else if (tick) begin
            unique case (st)
                CH_IDLE, CH_ON: begin
                end
                CH_OPEN_WAIT: begin
                    if (cnt_inc == open_dly) begin
                        st_nxt  = CH_ON;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt_inc;
                    end
                end
                CH_CLOSE_LIT, CH_CLOSE_DARK: begin
                    if (cnt_inc == close_dly) begin
                        st_nxt  = CH_IDLE;
                        cnt_nxt = '0;
                    end else begin
                        cnt_nxt = cnt_inc;
                    end
                end
                default: begin
                    st_nxt  = CH_IDLE;
                    cnt_nxt = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= CH_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    // outputs
    always_comb begin
        lit  = (st == CH_ON) || (st == CH_CLOSE_LIT);
        gate = lit & enable;
    end
endmodule

// File: rtl/expo_seq.sv
module expo_seq
    import expo_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_rise,
    input  logic             end_rise,
    input  logic             arm_set,
    input  logic             clr_cnt,
    input  logic             clr_ovr,
    output logic             start_acc,
    output logic             end_acc,
    output logic             armed,
    output logic             exposing,
    output logic             done,
    output logic             overrun,
    output logic [CNT_W-1:0] count
);
    seq_state_t st, st_nxt;
    logic       ovr_set;

    always_comb begin
        st_nxt = st;
        unique case (st)
            SEQ_IDLE:   if (arm_set)    st_nxt = SEQ_ARMED;
            SEQ_ARMED:  if (start_rise) st_nxt = SEQ_EXPOSE;
            SEQ_EXPOSE: if (end_rise)   st_nxt = arm_set ? SEQ_ARMED : SEQ_IDLE;
            default:                    st_nxt = SEQ_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SEQ_IDLE;
        else        st <= st_nxt;
    end

    // outputs and flags
    always_comb begin
        start_acc = start_rise && (st == SEQ_ARMED);
        end_acc   = end_rise && (st == SEQ_EXPOSE);
        ovr_set   = start_rise && (st == SEQ_EXPOSE);
        armed     = (st != SEQ_IDLE);
        exposing  = (st == SEQ_EXPOSE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done    <= 1'b0;
            overrun <= 1'b0;
            count   <= '0;
        end else begin
            if (start_acc)    done <= 1'b0;
            else if (end_acc) done <= 1'b1;
            overrun <= (overrun & ~clr_ovr) | ovr_set;
            if (clr_cnt)      count <= '0;
            else if (end_acc) count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/expo_gate_sync.sv
module expo_gate_sync
    import expo_gate_pkg::*;
#(
    parameter int TICK_DIV = 1250
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_trig,
    input  logic        end_trig,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        shutter_gate,
    output logic        detector_gate,
    output logic        monitor_gate
);
    logic                         start_rise, end_rise, tick;
    logic                         start_acc, end_acc;
    logic                         armed, exposing, done, overrun;
    logic [CNT_W-1:0]             exp_count;
    logic                         ctrl_wr, arm_set, clr_cnt, clr_ovr;
    logic [N_CH-1:0]              en_q;
    logic [N_CH-1:0][REG_DW-1:0]  dly_q;
    logic [N_CH-1:0]              lit_vec, gate_vec;

    expo_edge_sync u_sync_start (.clk(clk), .rst_n(rst_n), .raw(start_trig), .rise(start_rise));
    expo_edge_sync u_sync_end   (.clk(clk), .rst_n(rst_n), .raw(end_trig),   .rise(end_rise));

    expo_timebase #(.TICK_DIV(TICK_DIV)) u_tb (.clk(clk), .rst_n(rst_n), .tick(tick));

    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign arm_set = ctrl_wr && bus_wdata[C_ARM];
    assign clr_cnt = ctrl_wr && bus_wdata[C_CLR_CNT];
    assign clr_ovr = ctrl_wr && bus_wdata[C_CLR_OVR];

    expo_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_rise(start_rise),
        .end_rise  (end_rise),
        .arm_set   (arm_set),
        .clr_cnt   (clr_cnt),
        .clr_ovr   (clr_ovr),
        .start_acc (start_acc),
        .end_acc   (end_acc),
        .armed     (armed),
        .exposing  (exposing),
        .done      (done),
        .overrun   (overrun),
        .count     (exp_count)
    );

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            dly_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_EN) en_q <= bus_wdata[N_CH-1:0];
            for (int i = 0; i < N_CH; i++) begin
                if (bus_addr == REG_AW'(A_DLY0 + i)) dly_q[i] <= bus_wdata;
            end
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata = {exp_count, 12'd0, overrun, done, exposing, armed};
        end else if (bus_addr == A_EN) begin
            bus_rdata[N_CH-1:0] = en_q;
        end
        for (int i = 0; i < N_CH; i++) begin
            if (bus_addr == REG_AW'(A_DLY0 + i)) bus_rdata = dly_q[i];
        end
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        expo_gate_chan #(.DW(DLY_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .start_ev (start_acc),
            .end_ev   (end_acc),
            .open_dly (dly_q[g][DLY_W-1:0]),
            .close_dly(dly_q[g][2*DLY_W-1:DLY_W]),
            .enable   (en_q[g]),
            .lit      (lit_vec[g]),
            .gate     (gate_vec[g])
        );
    end

    assign shutter_gate  = gate_vec[0];
    assign detector_gate = gate_vec[1];
    assign monitor_gate  = gate_vec[2];
endmodule

// File: rtl/expo_gate_checks.sv
module expo_gate_checks (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  lit,
    input logic        armed,
    input logic        exposing,
    input logic        done,
    input logic        overrun,
    input logic        ovr_clr,
    input logic [15:0] count,
    input logic        cnt_clr
);
    // R2: the window opens only from the armed state
    p_expo_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exposing) |-> $past(armed));

    // R3: overrun holds until a clear write
    p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(overrun) && !$past(ovr_clr)) |-> overrun);

    // R4: closing the window reports done
    p_end_sets_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(exposing) |-> done);

    // R4: a new window clears done
    p_start_clears_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exposing) |-> !done);

    // R10: each completed exposure adds exactly one
    p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(exposing) && !$past(cnt_clr)) |-> (count == $past(count) + 16'd1));

    // R8: a channel only turns on inside an open window
    for (genvar i = 0; i < 3; i++) begin : g_lit
        p_lit_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lit[i]) |-> exposing);
    end
endmodule

bind expo_gate_sync expo_gate_checks u_checks (
    .clk     (clk),
    .rst_n   (rst_n),
    .lit     (lit_vec),
    .armed   (armed),
    .exposing(exposing),
    .done    (done),
    .overrun (overrun),
    .ovr_clr (clr_ovr),
    .count   (exp_count),
    .cnt_clr (clr_cnt)
);

// File: tb/tb_expo_gate_sync.sv
module tb_expo_gate_sync;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_trig = 1'b0;
    logic        end_trig = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    wire  [31:0] bus_rdata;
    wire         shutter_gate, detector_gate, monitor_gate;

    int checks = 0;
    int errors = 0;

    expo_gate_sync #(.TICK_DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .start_trig(start_trig), .end_trig(end_trig),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shutter_gate(shutter_gate), .detector_gate(detector_gate), .monitor_gate(monitor_gate)
    );

    always #4 clk = ~clk;

    // behavioural reference model
    int       m_pc;
    bit [2:0] m_sh, m_eh;
    bit       m_armed, m_expo, m_done, m_ovr;
    int       m_count;
    bit [2:0] m_en;
    int       m_od [3];
    int       m_cd [3];
    int       m_ph [3];     // 0 off, 1 waiting to open, 2 on, 3 waiting to close
    int       m_left [3];
    bit       m_lit_close [3];

    function automatic logic [31:0] model_rd(input logic [2:0] a);
        logic [31:0] r;
        r = 32'd0;
        if (a == 3'd0) r = {m_count[15:0], 12'd0, m_ovr, m_done, m_expo, m_armed};
        else if (a == 3'd1) r = {29'd0, m_en};
        else if (a >= 3'd2 && a <= 3'd4) r = {m_cd[a-2][15:0], m_od[a-2][15:0]};
        return r;
    endfunction

    function automatic bit model_gate(input int i);
        return m_en[i] && (m_ph[i] == 2 || (m_ph[i] == 3 && m_lit_close[i]));
    endfunction

    always @(posedge clk) begin
        bit tk, sp, ep, acc_s, acc_e, wr0;
        if (!rst_n) begin
            m_pc = 0; m_sh = 0; m_eh = 0;
            m_armed = 0; m_expo = 0; m_done = 0; m_ovr = 0; m_count = 0; m_en = 0;
            for (int i = 0; i < 3; i++) begin
                m_od[i] = 0; m_cd[i] = 0; m_ph[i] = 0; m_left[i] = 0; m_lit_close[i] = 0;
            end
        end else begin
            tk    = (m_pc == DIV - 1);
            sp    = m_sh[1] && !m_sh[2];
            ep    = m_eh[1] && !m_eh[2];
            acc_s = sp && m_armed && !m_expo;
            acc_e = ep && m_expo;
            wr0   = bus_wr && bus_addr == 3'd0;
            for (int i = 0; i < 3; i++) begin
                if (acc_s) begin
                    if (m_od[i] == 0) m_ph[i] = 2;
                    else begin m_ph[i] = 1; m_left[i] = m_od[i]; end
                end else if (acc_e && (m_ph[i] == 1 || m_ph[i] == 2)) begin
                    m_lit_close[i] = (m_ph[i] == 2);
                    if (m_cd[i] == 0) m_ph[i] = 0;
                    else begin m_ph[i] = 3; m_left[i] = m_cd[i]; end
                end else if (tk && (m_ph[i] == 1 || m_ph[i] == 3)) begin
                    m_left[i] = m_left[i] - 1;
                    if (m_left[i] == 0) m_ph[i] = (m_ph[i] == 1) ? 2 : 0;
                end
            end
            m_ovr = (m_ovr && !(wr0 && bus_wdata[2])) || (sp && m_expo);
            if (acc_s) begin m_expo = 1; m_done = 0; end
            if (acc_e) begin m_expo = 0; m_done = 1; m_armed = 0; end
            if (wr0 && bus_wdata[0]) m_armed = 1;
            if (wr0 && bus_wdata[1]) m_count = 0;
            else if (acc_e) m_count = (m_count + 1) % 65536;
            if (bus_wr && bus_addr == 3'd1) m_en = bus_wdata[2:0];
            if (bus_wr && bus_addr >= 3'd2 && bus_addr <= 3'd4) begin
                m_od[bus_addr-2] = int'(bus_wdata[15:0]);
                m_cd[bus_addr-2] = int'(bus_wdata[31:16]);
            end
            m_pc = tk ? 0 : m_pc + 1;
            m_sh = {m_sh[1:0], start_trig};
            m_eh = {m_eh[1:0], end_trig};
        end
        #2;
        checks++;
        if (bus_rdata !== model_rd(bus_addr)) begin
            errors++;
            $display("FAIL R10/R11 read addr %0d act=%h exp=%h", bus_addr, bus_rdata, model_rd(bus_addr));
        end
        if ({monitor_gate, detector_gate, shutter_gate} !==
            {model_gate(2), model_gate(1), model_gate(0)}) begin
            errors++;
            $display("FAIL R5/R6/R7 gates act=%b exp=%b at %0t",
                     {monitor_gate, detector_gate, shutter_gate},
                     {model_gate(2), model_gate(1), model_gate(0)}, $time);
        end
    end

    // detector watch for the early-end case
    bit det_watch = 0, det_seen = 0;
    always @(posedge clk) if (det_watch && detector_gate) det_seen = 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); bus_addr = a;
        @(posedge clk); #3;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_trig = 1'b1;
        repeat (2) @(negedge clk); start_trig = 1'b0;
    endtask

    task automatic pulse_end();
        @(negedge clk); end_trig = 1'b1;
        repeat (2) @(negedge clk); end_trig = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        rd_chk(3'd0, 32'h0, "R11 status after reset");
        rd_chk(3'd3, 32'h0, "R11 delay after reset");
        chk("R11 gates after reset", {29'd0, monitor_gate, detector_gate, shutter_gate}, 32'h0);

        wr(3'd1, 32'd7);
        wr(3'd2, 32'h0000_0000);
        wr(3'd3, {16'd2, 16'd3});
        wr(3'd4, {16'd5, 16'd1});
        rd_chk(3'd3, {16'd2, 16'd3}, "R11 detector delay readback");
        rd_chk(3'd1, 32'd7, "R9 enable readback");

        // R2 start while disarmed
        pulse_start(); idle(6);
        rd_chk(3'd0, 32'h0, "R2 start ignored when disarmed");

        wr(3'd0, 32'd1);
        rd_chk(3'd0, 32'h1, "R2 armed flag");

        // R1 latency, R6 zero-delay shutter
        @(negedge clk); start_trig = 1'b1; bus_addr = 3'd0;
        @(posedge clk); #3; chk("R1 not yet at edge k", bus_rdata[1], 1'b0);
        @(posedge clk); #3; chk("R1 not yet at edge k+1", bus_rdata[1], 1'b0);
        @(posedge clk); #3; chk("R1 exposing at edge k+2", bus_rdata[1], 1'b1);
        chk("R6 zero open delay shutter", shutter_gate, 1'b1);
        @(negedge clk); start_trig = 1'b0;
        idle(20);
        chk("R6 detector open", detector_gate, 1'b1);
        chk("R6 monitor open", monitor_gate, 1'b1);

        // R3 overrun
        pulse_start(); idle(6);
        rd_chk(3'd0, 32'h0000_000B, "R3 overrun set, exposure kept");

        // R4 end
        pulse_end(); idle(2);
        rd_chk(3'd0, 32'h0001_000C, "R4 end closes window");
        chk("R7 zero close delay shutter", shutter_gate, 1'b0);
        idle(30);
        chk("R7 all gates closed", {29'd0, monitor_gate, detector_gate, shutter_gate}, 32'h0);

        wr(3'd0, 32'd4);
        rd_chk(3'd0, 32'h0001_0004, "R3 overrun cleared");
        pulse_end(); idle(6);
        rd_chk(3'd0, 32'h0001_0004, "R4 end ignored when idle");

        // R8 early end
        wr(3'd3, {16'd2, 16'd12});
        wr(3'd0, 32'd1);
        det_seen = 0; det_watch = 1;
        pulse_start(); idle(10);
        pulse_end(); idle(60);
        det_watch = 0;
        chk("R8 detector never opened", {31'd0, det_seen}, 32'd0);
        rd_chk(3'd0, 32'h0002_0004, "R8 exposure still counted");

        // R9 enable masking
        wr(3'd3, {16'd2, 16'd3});
        wr(3'd0, 32'd1);
        pulse_start(); idle(30);
        chk("R9 detector on before mask", detector_gate, 1'b1);
        wr(3'd1, 32'd5);
        chk("R9 detector masked", detector_gate, 1'b0);
        chk("R9 monitor unaffected", monitor_gate, 1'b1);
        wr(3'd1, 32'd7);
        chk("R9 detector restored", detector_gate, 1'b1);
        pulse_end(); idle(40);

        // R10 count and clear
        rd_chk(3'd0, 32'h0003_0004, "R10 count of three");
        wr(3'd0, 32'd2);
        rd_chk(3'd0, 32'h0000_0004, "R10 count cleared");

        idle(4);
        summary();
        $finish;
    end
endmodule